// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects thirty-two interrupt request inputs and turns them into two active-low request lines towards a processor: a normal line and a fast line. Each input has its own enable bit, its own trigger setting (level or edge, with a selectable polarity on the inputs that come from outside the chip), its own three-bit priority and its own 32-bit handler address. Input 0 is the dedicated fast request. Input 1 is meant to carry the OR of the system peripheral requests. Inputs 1 to 31 compete for the normal line.

Software reads the current-vector register to get the handler address of the winning normal request. That read also acknowledges the request: it clears an edge-latched request and pushes the winner's priority onto a nesting stack. While an entry is on the stack, only a strictly higher priority can assert the normal line again. A write to the end-of-service register pops the stack. A protect setting makes reads free of side effects so that a debugger can inspect the block. While it is on, a write to the current-vector register performs the acknowledge instead. Any normal input can be forced onto the fast line.

Access is a simple word-addressed register bus. A read request returns its data on the clock edge that accepts it. Mode registers sit at addresses 0x00+n and vector registers at 0x20+n, where n is the source number. The control registers are: current vector 0x40, fast vector 0x41, in-service source 0x42, raw pending 0x43, enable mask 0x44, enable-set 0x45, enable-clear 0x46, pending-clear 0x47, end-of-service 0x48, spurious vector 0x49, control 0x4A (bit 0 is protect), force-set 0x4B, force-clear 0x4C and force status 0x4D.

Top module: `vpic_top`

## Requirements
- R1: After reset both request lines are high, the enable mask reads 0, the in-service source reads 0 and the current-vector register returns the spurious vector, whose reset value is 0.
- R2: A source raises a request line only while its mask bit is set. Writing 1s to enable-set (0x45) sets mask bits, writing 1s to enable-clear (0x46) clears them, and the mask reads back at 0x44.
- R3: Source 0, when enabled and active, pulls only the fast line low, never the normal line. A read of the fast-vector register (0x41) returns the vector of source 0.
- R4: A mode word has priority in bits [2:0], trigger in bit 3 (0 level, 1 edge) and polarity in bit 4 (1 high/rising, 0 low/falling). Sources 1 to 28 are internal and ignore the polarity bit, so they always act on a high level or a rising edge.
- R5: An edge-triggered source stays pending after its input returns to idle. Its pending bit is cleared by its acknowledge or by writing a 1 to its bit in pending-clear (0x47). The raw pending vector reads at 0x43.
- R6: External sources 0, 29, 30 and 31 honour the polarity bit: low-level and falling-edge settings make the source pending on a low input and on a falling input respectively.
- R7: Among enabled, unforced normal requests, the highest priority wins and equal priorities go to the lowest source number. A read of the current vector (0x40) returns the winner's vector register.
- R8: A normal read of 0x40 pushes the winner onto the nesting stack. The normal line then stays high unless a strictly higher priority is pending. The in-service register (0x42) shows the source on top of the stack, and a write to end-of-service (0x48) pops one entry.
- R9: When no request is above the current service level, a read of 0x40 returns the spurious vector register (0x49) and does not push.
- R10: With protect set (control bit 0), reads of 0x40 have no side effect. A write to 0x40 then performs the acknowledge and push.
- R11: A source whose force bit is set (force-set 0x4B, force-clear 0x4C, status 0x4D) drives the fast line and drops out of normal arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Interrupt request inputs, one per source |
| bus_rd | input | 1 | Register read request |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the accepting edge |
| nirq_n | output | 1 | Normal interrupt request, active low |
| nfiq_n | output | 1 | Fast interrupt request, active low |

## Verification
An input change is captured on the first rising edge and appears on the request lines after the second. A bus write or an acknowledge changes internal state on its own edge, and the lines follow one edge later. Read data is registered on the edge that accepts the read. The bench therefore drives on falling edges and checks line levels two falling edges after an input change, or one falling edge after a write or read completes. A scoreboard queue holds the expected read data and is compared on the falling edge after each accepted read, so nesting, protect and spurious cases are checked in the exact order the reads were issued.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int NUM_SRC    = 32;
    localparam int SRC_W      = $clog2(NUM_SRC);
    localparam int PRIO_W     = 3;
    localparam int NEST_DEPTH = 1 << PRIO_W;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int PAGE_W     = ADDR_W - SRC_W;

    localparam logic [PAGE_W-1:0] PG_MODE = PAGE_W'(0);
    localparam logic [PAGE_W-1:0] PG_VEC  = PAGE_W'(1);

    localparam logic [ADDR_W-1:0] A_VEC_NOW    = 8'h40;
    localparam logic [ADDR_W-1:0] A_VEC_FAST   = 8'h41;
    localparam logic [ADDR_W-1:0] A_SRC_NOW    = 8'h42;
    localparam logic [ADDR_W-1:0] A_PEND       = 8'h43;
    localparam logic [ADDR_W-1:0] A_MASK       = 8'h44;
    localparam logic [ADDR_W-1:0] A_MASK_SET   = 8'h45;
    localparam logic [ADDR_W-1:0] A_MASK_CLR   = 8'h46;
    localparam logic [ADDR_W-1:0] A_ACK_CLR    = 8'h47;
    localparam logic [ADDR_W-1:0] A_DONE       = 8'h48;
    localparam logic [ADDR_W-1:0] A_SPUR       = 8'h49;
    localparam logic [ADDR_W-1:0] A_CTRL       = 8'h4A;
    localparam logic [ADDR_W-1:0] A_FORCE_SET  = 8'h4B;
    localparam logic [ADDR_W-1:0] A_FORCE_CLR  = 8'h4C;
    localparam logic [ADDR_W-1:0] A_FORCE_STAT = 8'h4D;

    localparam int MODE_W = PRIO_W + 2;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    // bit 4 polarity, bit 3 trigger, bits [2:0] priority
    typedef struct packed {
        logic              pol;
        trig_e             trig;
        logic [PRIO_W-1:0] prio;
    } mode_t;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] lvl;
    } nest_ent_t;

    function automatic logic [NUM_SRC-1:0] src_onehot(input logic [SRC_W-1:0] idx);
        logic [NUM_SRC-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] mode_word(input mode_t m);
        return DATA_W'(m);
    endfunction

endpackage

// File: rtl/vpic_trigger.sv
module vpic_trigger
    import vpic_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] EXT_MASK = 32'hE000_0001
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] edge_sel,
    input  logic [NUM_SRC-1:0] pol_sel,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] edge_q;
    logic [NUM_SRC-1:0] pol_eff;
    logic [NUM_SRC-1:0] hit;
    logic [NUM_SRC-1:0] lvl_now;

    // internal sources always see high level / rising edge
    assign pol_eff = pol_sel | ~EXT_MASK;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign lvl_now[g] = pol_eff[g] ? src_q[g] : ~src_q[g];
        assign hit[g]     = edge_sel[g] &
                            (pol_eff[g] ? (src_in[g] & ~src_q[g])
                                        : (~src_in[g] & src_q[g]));
        assign pend[g]    = edge_sel[g] ? edge_q[g] : lvl_now[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            edge_q <= '0;
        end else begin
            src_q  <= src_in;
            edge_q <= (hit | (edge_q & ~clr)) & edge_sel;
        end
    end

endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
    import vpic_pkg::*;
(
    input  logic [NUM_SRC-1:0]             cand,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output logic                           win_vld,
    output logic [SRC_W-1:0]               win_idx,
    output logic [PRIO_W-1:0]              win_lvl
);

    // ascending scan with strict compare: ties keep the lower index
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && (!win_vld || (prio[i] > win_lvl))) begin
                win_vld = 1'b1;
                win_idx = SRC_W'(i);
                win_lvl = prio[i];
            end
        end
    end

endmodule

// File: rtl/vpic_nest_stack.sv
module vpic_nest_stack
    import vpic_pkg::*;
#(
    parameter int DEPTH = NEST_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  nest_ent_t        push_ent,
    output nest_ent_t        top_ent,
    output logic [CNT_W-1:0] cnt,
    output logic             empty
);

    nest_ent_t        ent_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;

    assign cnt     = cnt_q;
    assign empty   = (cnt_q == '0);
    assign top_ent = empty ? '0 : ent_q[IDX_W'(cnt_q - 1'b1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else if (push && (cnt_q < CNT_W'(DEPTH))) begin
            ent_q[IDX_W'(cnt_q)] <= push_ent;
            cnt_q                <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] EXT_MASK = 32'hE000_0001,
    parameter int                 DEPTH    = NEST_DEPTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               nirq_n,
    output logic               nfiq_n
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [NUM_SRC-1:0] NOT_FAST = ~NUM_SRC'(1);

    // register state
    mode_t              mode_q [NUM_SRC];
    logic [DATA_W-1:0]  vec_q  [NUM_SRC];
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] force_q;
    logic [DATA_W-1:0]  spur_q;
    logic               protect_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               nirq_q;
    logic               nfiq_q;

    // decode
    logic [PAGE_W-1:0]  page;
    logic [SRC_W-1:0]   slot;
    logic               hit_vec_now;

    // datapath
    logic [NUM_SRC-1:0]             edge_sel;
    logic [NUM_SRC-1:0]             pol_sel;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec;
    logic [NUM_SRC-1:0]             pend;
    logic [NUM_SRC-1:0]             clr;
    logic [NUM_SRC-1:0]             act;
    logic [NUM_SRC-1:0]             norm_cand;
    logic                           win_vld;
    logic [SRC_W-1:0]               win_idx;
    logic [PRIO_W-1:0]              win_lvl;
    nest_ent_t                      top_ent;
    nest_ent_t                      push_ent;
    logic [CNT_W-1:0]               stk_cnt;
    logic                           stk_empty;
    logic                           irq_cond;
    logic                           fiq_cond;
    logic                           ack;
    logic                           fast_ack;
    logic                           pop;
    logic [DATA_W-1:0]              rd_next;

    assign page        = bus_addr[ADDR_W-1:SRC_W];
    assign slot        = bus_addr[SRC_W-1:0];
    assign hit_vec_now = (bus_addr == A_VEC_NOW);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mode
        assign edge_sel[g] = (mode_q[g].trig == TRIG_EDGE);
        assign pol_sel[g]  = mode_q[g].pol;
        assign prio_vec[g] = mode_q[g].prio;
    end

    vpic_trigger #(
        .EXT_MASK (EXT_MASK)
    ) u_trigger (
        .clk      (clk),
        .rst      (rst),
        .src_in   (irq_src),
        .edge_sel (edge_sel),
        .pol_sel  (pol_sel),
        .clr      (clr),
        .pend     (pend)
    );

    assign act       = pend & mask_q;
    assign norm_cand = act & ~force_q & NOT_FAST;
    assign fiq_cond  = act[0] | (|(act & force_q & NOT_FAST));

    vpic_arbiter u_arbiter (
        .cand    (norm_cand),
        .prio    (prio_vec),
        .win_vld (win_vld),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    assign irq_cond = win_vld && (stk_empty || (win_lvl > top_ent.lvl));

    // acknowledge: normal read, or write while protected
    assign ack      = irq_cond &&
                      ((bus_rd && hit_vec_now && !protect_q) ||
                       (bus_wr && hit_vec_now &&  protect_q));
    assign fast_ack = bus_rd && (bus_addr == A_VEC_FAST) && !protect_q;
    assign pop      = bus_wr && (bus_addr == A_DONE);

    assign push_ent.src = win_idx;
    assign push_ent.lvl = win_lvl;

    assign clr = (ack ? src_onehot(win_idx) : '0)
               | (fast_ack ? NUM_SRC'(1) : '0)
               | ((bus_wr && (bus_addr == A_ACK_CLR)) ? NUM_SRC'(bus_wdata) : '0);

    vpic_nest_stack #(
        .DEPTH (DEPTH)
    ) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (ack),
        .pop      (pop),
        .push_ent (push_ent),
        .top_ent  (top_ent),
        .cnt      (stk_cnt),
        .empty    (stk_empty)
    );

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                mode_q[i] <= '0;
                vec_q[i]  <= '0;
            end
            mask_q    <= '0;
            force_q   <= '0;
            spur_q    <= '0;
            protect_q <= 1'b0;
        end else if (bus_wr) begin
            if (page == PG_MODE) begin
                mode_q[slot] <= mode_t'(bus_wdata[MODE_W-1:0]);
            end else if (page == PG_VEC) begin
                vec_q[slot] <= bus_wdata;
            end else begin
                case (bus_addr)
                    A_MASK_SET:  mask_q    <= mask_q | NUM_SRC'(bus_wdata);
                    A_MASK_CLR:  mask_q    <= mask_q & ~NUM_SRC'(bus_wdata);
                    A_FORCE_SET: force_q   <= force_q | (NUM_SRC'(bus_wdata) & NOT_FAST);
                    A_FORCE_CLR: force_q   <= force_q & ~NUM_SRC'(bus_wdata);
                    A_SPUR:      spur_q    <= bus_wdata;
                    A_CTRL:      protect_q <= bus_wdata[0];
                    default:     ;
                endcase
            end
        end
    end

    // read mux
    always_comb begin
        rd_next = '0;
        if (page == PG_MODE) begin
            rd_next = mode_word(mode_q[slot]);
        end else if (page == PG_VEC) begin
            rd_next = vec_q[slot];
        end else begin
            case (bus_addr)
                A_VEC_NOW:    rd_next = irq_cond ? vec_q[win_idx] : spur_q;
                A_VEC_FAST:   rd_next = vec_q[0];
                A_SRC_NOW:    rd_next = DATA_W'(top_ent.src);
                A_PEND:       rd_next = DATA_W'(pend);
                A_MASK:       rd_next = DATA_W'(mask_q);
                A_SPUR:       rd_next = spur_q;
                A_CTRL:       rd_next = DATA_W'(protect_q);
                A_FORCE_STAT: rd_next = DATA_W'(force_q);
                default:      rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            nirq_q  <= 1'b1;
            nfiq_q  <= 1'b1;
        end else begin
            if (bus_rd) begin
                rdata_q <= rd_next;
            end
            nirq_q <= ~irq_cond;
            nfiq_q <= ~fiq_cond;
        end
    end

    assign bus_rdata = rdata_q;
    assign nirq_n    = nirq_q;
    assign nfiq_n    = nfiq_q;

endmodule

// File: rtl/vpic_checker.sv
module vpic_checker
    import vpic_pkg::*;
#(
    parameter int DEPTH = NEST_DEPTH,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               nirq_n,
    input logic               nfiq_n,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               protect_q,
    input logic               irq_cond,
    input logic [CNT_W-1:0]   stk_cnt
);

    AST_LINES_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (nirq_n && nfiq_n)); // R1

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> (nirq_n && nfiq_n)); // R2

    AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == A_VEC_NOW) && !protect_q && irq_cond
         && (stk_cnt < CNT_W'(DEPTH)))
        |=> (stk_cnt == CNT_W'($past(stk_cnt) + 1'b1))); // R8

    AST_DONE_POPS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == A_DONE) && (stk_cnt != '0))
        |=> (stk_cnt == CNT_W'($past(stk_cnt) - 1'b1))); // R8

    AST_SPURIOUS_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == A_VEC_NOW) && !irq_cond) |=> $stable(stk_cnt)); // R9

    AST_PROTECT_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == A_VEC_NOW) && protect_q) |=> $stable(stk_cnt)); // R10

endmodule

bind vpic_top vpic_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_vpic_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .nirq_n    (nirq_n),
    .nfiq_n    (nfiq_n),
    .mask_q    (mask_q),
    .protect_q (protect_q),
    .irq_cond  (irq_cond),
    .stk_cnt   (stk_cnt)
);

// File: tb/test_vpic_top.sv
module test_vpic_top;
    import vpic_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic [NUM_SRC-1:0] irq_src;
    logic               bus_rd;
    logic               bus_wr;
    logic [ADDR_W-1:0]  bus_addr;
    logic [DATA_W-1:0]  bus_wdata;
    logic [DATA_W-1:0]  bus_rdata;
    logic               nirq_n;
    logic               nfiq_n;

    int checks = 0;
    int errors = 0;
    logic rd_seen = 1'b0;
    logic done = 1'b0;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             tag;
    } sb_item_t;

    sb_item_t exp_q[$];
    sb_item_t cur;

    always #2 clk = ~clk;

    vpic_top i_vpic_top (
        .clk       (clk),
        .rst       (rst),
        .irq_src   (irq_src),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .nirq_n    (nirq_n),
        .nfiq_n    (nfiq_n)
    );

    function automatic logic [DATA_W-1:0] vec_of(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h10;
    endfunction

    function automatic logic [DATA_W-1:0] mw(input int prio, input bit edge_m, input bit pol);
        return {27'd0, pol, edge_m, 3'(prio)};
    endfunction

    // monitor: compare read data the falling edge after an accepted read
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
            end else begin
                cur = exp_q.pop_front();
                if (bus_rdata !== cur.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", cur.tag, bus_rdata, cur.exp);
                end
            end
        end
    end

    task automatic wait_cy(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
        sb_item_t it;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
        bus_rd   = 1'b1;
        bus_addr = a;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic chk_lines(input logic e_irq, input logic e_fiq, input string tag);
        checks++;
        if ((nirq_n !== e_irq) || (nfiq_n !== e_fiq)) begin
            errors++;
            $display("FAIL %s: actual nirq_n=%b nfiq_n=%b expected nirq_n=%b nfiq_n=%b",
                     tag, nirq_n, nfiq_n, e_irq, e_fiq);
        end
    endtask

    initial begin
        rst = 1'b1; irq_src = '0; bus_rd = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        wait_cy(3);
        rst = 1'b0;
        chk_lines(1'b1, 1'b1, "R1 lines after reset");
        bus_read(A_MASK, 32'h0, "R1 mask after reset");
        bus_read(A_SRC_NOW, 32'h0, "R1 in-service after reset");
        bus_read(A_VEC_NOW, 32'h0, "R1 spurious after reset");

        for (int i = 0; i < NUM_SRC; i++) begin
            bus_write(8'h20 + 8'(i), vec_of(i));
            bus_write(8'h00 + 8'(i), mw(0, 1'b0, 1'b1));
        end
        bus_write(A_SPUR, 32'hDEAD_0000);

        // R2 masking
        bus_write(8'h05, mw(2, 1'b0, 1'b1));
        irq_src[5] = 1'b1;
        wait_cy(2);
        chk_lines(1'b1, 1'b1, "R2 masked source quiet");
        bus_write(A_MASK_SET, 32'h20);
        wait_cy(1);
        chk_lines(1'b0, 1'b1, "R2 enabled source asserts");
        bus_read(A_MASK, 32'h20, "R2 mask readback");

        // R7 priority with protected reads (R10)
        bus_write(A_CTRL, 32'h1);
        bus_write(8'h07, mw(2, 1'b0, 1'b1));
        irq_src[7] = 1'b1;
        bus_write(A_MASK_SET, 32'h80);
        wait_cy(2);
        bus_read(A_VEC_NOW, vec_of(5), "R7 tie goes to lower index");
        bus_write(8'h09, mw(5, 1'b0, 1'b1));
        irq_src[9] = 1'b1;
        bus_write(A_MASK_SET, 32'h200);
        wait_cy(2);
        bus_read(A_VEC_NOW, vec_of(9), "R7 higher priority wins");
        bus_read(A_SRC_NOW, 32'h0, "R10 protected read does not push");

        // R8 nesting
        irq_src[9] = 1'b0;
        bus_write(A_MASK_CLR, 32'h200);
        bus_write(A_CTRL, 32'h0);
        wait_cy(2);
        bus_read(A_VEC_NOW, vec_of(5), "R8 ack returns winner");
        wait_cy(1);
        chk_lines(1'b1, 1'b1, "R8 equal level masked by service");
        bus_read(A_SRC_NOW, 32'd5, "R8 in-service after push");
        irq_src[9] = 1'b1;
        bus_write(A_MASK_SET, 32'h200);
        wait_cy(1);
        chk_lines(1'b0, 1'b1, "R8 higher level nests");
        bus_read(A_VEC_NOW, vec_of(9), "R8 nested ack");
        bus_read(A_SRC_NOW, 32'd9, "R8 nested in-service");
        irq_src[9] = 1'b0;
        wait_cy(2);
        chk_lines(1'b1, 1'b1, "R8 line high during nested service");
        bus_write(A_DONE, 32'h0);
        bus_read(A_SRC_NOW, 32'd5, "R8 pop restores outer");
        chk_lines(1'b1, 1'b1, "R8 outer level still blocks equal");
        bus_write(A_DONE, 32'h0);
        bus_read(A_SRC_NOW, 32'd0, "R8 stack empty after pops");
        chk_lines(1'b0, 1'b1, "R8 pending requests reassert");
        irq_src[5] = 1'b0;
        irq_src[7] = 1'b0;
        bus_write(A_MASK_CLR, 32'hFFFF_FFFF);

        // R9 spurious
        wait_cy(2);
        bus_read(A_VEC_NOW, 32'hDEAD_0000, "R9 spurious vector");
        bus_read(A_SRC_NOW, 32'h0, "R9 no push on spurious");

        // R5 edge latching
        bus_write(8'h0C, mw(3, 1'b1, 1'b1));
        bus_write(A_MASK_SET, 32'h1000);
        irq_src[12] = 1'b1;
        wait_cy(1);
        irq_src[12] = 1'b0;
        wait_cy(2);
        chk_lines(1'b0, 1'b1, "R5 edge latched after input drops");
        bus_read(A_PEND, 32'h1000, "R5 pending bit set");
        bus_write(A_ACK_CLR, 32'h1000);
        wait_cy(1);
        chk_lines(1'b1, 1'b1, "R5 cleared by pending-clear");
        irq_src[12] = 1'b1;
        wait_cy(1);
        irq_src[12] = 1'b0;
        wait_cy(2);
        bus_read(A_VEC_NOW, vec_of(12), "R5 edge source acked");
        bus_read(A_PEND, 32'h0, "R5 ack clears edge");
        bus_write(A_DONE, 32'h0);
        bus_write(A_MASK_CLR, 32'h1000);

        // R4 internal source ignores polarity bit
        bus_write(8'h0E, mw(0, 1'b0, 1'b0));
        wait_cy(1);
        bus_read(A_PEND, 32'h0, "R4 internal low input not pending");
        irq_src[14] = 1'b1;
        wait_cy(1);
        bus_read(A_PEND, 32'h4000, "R4 internal high input pending");
        irq_src[14] = 1'b0;

        // R6 external polarity
        bus_write(8'h1E, mw(1, 1'b0, 1'b0));
        wait_cy(1);
        bus_read(A_PEND, 32'h4000_0000, "R6 external low level pending");
        irq_src[30] = 1'b1;
        wait_cy(1);
        bus_read(A_PEND, 32'h0, "R6 external low level released");
        irq_src[29] = 1'b1;
        bus_write(8'h1D, mw(0, 1'b1, 1'b0));
        wait_cy(1);
        bus_read(A_PEND, 32'h0, "R6 falling edge idle");
        irq_src[29] = 1'b0;
        wait_cy(1);
        bus_read(A_PEND, 32'h2000_0000, "R6 falling edge detected");
        irq_src[29] = 1'b1;
        wait_cy(1);
        bus_read(A_PEND, 32'h2000_0000, "R5 falling edge stays latched");
        bus_write(A_ACK_CLR, 32'h2000_0000);
        bus_read(A_PEND, 32'h0, "R5 external edge cleared");

        // R3 fast source
        bus_write(A_MASK_SET, 32'h1);
        irq_src[0] = 1'b1;
        wait_cy(2);
        chk_lines(1'b1, 1'b0, "R3 source 0 drives fast line only");
        bus_read(A_VEC_FAST, vec_of(0), "R3 fast vector");
        irq_src[0] = 1'b0;
        wait_cy(2);
        chk_lines(1'b1, 1'b1, "R3 fast line released");
        bus_write(A_MASK_CLR, 32'h1);

        // R11 fast forcing
        bus_write(8'h14, mw(6, 1'b0, 1'b1));
        bus_write(A_MASK_SET, 32'h10_0000);
        irq_src[20] = 1'b1;
        wait_cy(2);
        chk_lines(1'b0, 1'b1, "R11 unforced source on normal line");
        bus_write(A_FORCE_SET, 32'h10_0000);
        wait_cy(1);
        chk_lines(1'b1, 1'b0, "R11 forced source on fast line");
        bus_read(A_FORCE_STAT, 32'h10_0000, "R11 force status");
        bus_write(A_FORCE_CLR, 32'h10_0000);
        wait_cy(1);
        chk_lines(1'b0, 1'b1, "R11 force removed");

        // R10 protected write acknowledges
        bus_write(A_CTRL, 32'h1);
        bus_read(A_VEC_NOW, vec_of(20), "R10 protected read value");
        bus_read(A_SRC_NOW, 32'h0, "R10 protected read no push");
        bus_write(A_VEC_NOW, 32'h0);
        bus_read(A_SRC_NOW, 32'd20, "R10 protected write pushes");
        chk_lines(1'b1, 1'b1, "R10 line high after protected ack");
        bus_write(A_DONE, 32'h0);
        bus_write(A_CTRL, 32'h0);

        wait_cy(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule